// File: doc/BRIEF.md
# Serial Register Control Port

This block is the slave end of a five-wire serial control link through which a host microcontroller writes and reads the configuration registers of a larger device. The host drives a data input, a serial clock and an active-low select. The block returns a data output with its own output enable and an active-low interrupt. Every transfer is one frame of sixteen clock pulses, made of a command byte and a data byte. Data moves in both directions at once, most significant bit first. The block detects the idle level of the clock for each frame. A mode bit chooses which edge of each pulse samples the input and which edge advances the output.

Reads never return data directly. A read-back command queues a reply, and the block then pulls the interrupt low. The host collects the reply in a later frame, and spontaneous status reports from the surrounding logic travel the same way. All host-side signals are brought into a system clock that runs at least eight times faster than the serial clock. Register values are committed only when a frame ends with exactly sixteen pulses.

Top module: `ctl_serial_port`

## Requirements
- R1: A command takes effect only if its frame has exactly 16 clock pulses (32 edges) while ser_cs_n is low, and only after ser_cs_n rises. A shorter or longer frame writes nothing and does not consume the message it carried.
- R2: The first clock edge after ser_cs_n falls is edge 1, whether it is rising or falling, so frames with the clock idling high or low behave the same.
- R3: In mode A (cfg_mode_b = 0), the input is sampled on odd edges and the output advances on even edges. Output bit 15 is present from the start of the frame.
- R4: In mode B, the roles are swapped: even edges sample and odd edges from edge 3 on advance the output. Reset selects mode A. Writing command byte 0x20 (address 0x10, flag 0) with data bit 0 set to 1 selects mode B, and setting it to 0 selects mode A. The new mode applies from the next frame.
- R5: A command byte of {addr[6:0], 0} with addr below 8 writes the data byte into register addr, seen on cfg_regs[8*addr +: 8]. Writes to unmapped addresses have no effect.
- R6: A command byte of {addr[6:0], 1} is a read-back request, and the data byte is ignored. The block queues the reply {addr, 1}, value, where the value is the register content at the end of the frame (0 for unmapped addresses, {7'b0, mode} for 0x10).
- R7: A pulse on evt_valid while evt_ready is high queues the status report {evt_addr, 0}, evt_data.
- R8: A frame that starts with the queue empty sends 16 zero bits.
- R9: ser_irq_n is low while the queue is non-empty and ser_cs_n is high. It is high while ser_cs_n is low and never falls during a frame.
- R10: While ser_cs_n is high, ser_dout_oe and ser_dout are 0. During a frame, ser_dout_oe is 1.
- R11: A command byte with upper nibble 0xC writes {byte1[3:0], byte2} into the 12-bit cfg_wide register. A command byte with upper nibble 0xD queues the reply {0xD, cfg_wide[11:8]}, cfg_wide[7:0].
- R12: The queue holds 4 messages in arrival order and sends one per completed frame. Entries are added only while ser_cs_n is high. A status report that arrives during a frame, or while the queue is full, is held and evt_ready stays low until it is queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| ser_dout_oe | output | 1 | Output enable for ser_dout (0 = high impedance) |
| ser_irq_n | output | 1 | Active-low attention request |
| evt_valid | input | 1 | Status report strobe |
| evt_ready | output | 1 | Status report can be accepted |
| evt_addr | input | 7 | Address field of the status report |
| evt_data | input | 8 | Content of the status report |
| cfg_regs | output | 64 | Register file, register n at bits 8n+7..8n |
| cfg_wide | output | 12 | 12-bit register |
| cfg_mode_b | output | 1 | Edge-assignment mode (1 = mode B) |

## Verification
An output bit changes about four system cycles after the serial edge that advances it, because of the two synchronizer stages, the edge detector and the shift register. The host model therefore samples ser_dout a full half-period of eight cycles after that edge, just before the next edge. A command commits about four cycles after ser_cs_n rises, and the interrupt follows one cycle later. The bench waits twelve cycles after each frame before it compares registers, queue order and ser_irq_n with its model. After a status strobe it waits six cycles before it checks the interrupt.

// File: rtl/csp_pkg.sv
package csp_pkg;

   localparam int CSP_FRAME_BITS = 16;

   typedef struct packed {
      logic [7:0] hdr;
      logic [7:0] body;
   } csp_word_t;

   function automatic csp_word_t csp_make(input logic [6:0] addr,
                                          input logic       flag,
                                          input logic [7:0] data);
      csp_word_t w;
      w.hdr  = {addr, flag};
      w.body = data;
      return w;
   endfunction

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);

   initial begin : p_param_chk
      if (STAGES < 2) $error("csp_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("csp_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d_in;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_out = stg[STAGES-1];

endmodule

// File: rtl/csp_fifo.sv
module csp_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   initial begin : p_param_chk
      if (DEPTH < 2)                $error("csp_fifo: DEPTH must be at least 2");
      if ((1 << AW) != DEPTH)       $error("csp_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= push_data;
            wr_ptr      <= wr_ptr + 1'b1;
         end
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) (push && full) |-> pop) else $error("fifo overflow"); // R12
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty) else $error("fifo underflow"); // R12

endmodule

// File: rtl/csp_frame.sv
module csp_frame #(
   parameter int BITS = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s_sclk,
   input  logic            s_cs_n,
   input  logic            s_din,
   input  logic            mode_b_i,
   input  logic            tx_avail_i,
   input  logic [BITS-1:0] tx_word_i,
   output logic            dout_o,
   output logic            oe_o,
   output logic            done_o,
   output logic            had_msg_o,
   output logic [BITS-1:0] rx_word_o
);

   localparam int EDGES = 2 * BITS;
   localparam int CW    = $clog2(EDGES + 2);

   initial begin : p_param_chk
      if (BITS < 2) $error("csp_frame: BITS must be at least 2");
   end

   logic            sclk_d, cs_d, active, mode_q, had_q;
   logic [CW-1:0]   cnt;
   logic [BITS-1:0] tx_sh, rx_sh;
   logic            cs_fall, cs_rise, edge_seen, samp_edge, drv_edge;

   assign cs_fall   = cs_d & ~s_cs_n;
   assign cs_rise   = ~cs_d & s_cs_n;
   // any transition counts: the first one after select is edge 1 whatever its direction
   assign edge_seen = active & ~s_cs_n & (s_sclk ^ sclk_d) & (cnt <= CW'(EDGES));
   // count even before the edge means the edge is odd; mode A samples odd, mode B even
   assign samp_edge = edge_seen & (cnt[0] == mode_q);
   assign drv_edge  = edge_seen & ~samp_edge & (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
         active <= 1'b0;
         mode_q <= 1'b0;
         had_q  <= 1'b0;
         cnt    <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         done_o <= 1'b0;
      end else begin
         sclk_d <= s_sclk;
         cs_d   <= s_cs_n;
         done_o <= 1'b0;
         if (cs_fall) begin
            active <= 1'b1;
            cnt    <= '0;
            mode_q <= mode_b_i;
            had_q  <= tx_avail_i;
            tx_sh  <= tx_avail_i ? tx_word_i : '0;
            rx_sh  <= '0;
         end else if (cs_rise) begin
            active <= 1'b0;
            done_o <= active & (cnt == CW'(EDGES));
         end else if (edge_seen) begin
            cnt <= cnt + 1'b1;
            if (samp_edge) rx_sh <= {rx_sh[BITS-2:0], s_din};
            if (drv_edge)  tx_sh <= {tx_sh[BITS-2:0], 1'b0};
         end
      end
   end

   assign oe_o      = active;
   assign dout_o    = active & tx_sh[BITS-1];
   assign had_msg_o = had_q;
   assign rx_word_o = rx_sh;

   AST_MODE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (active && !cs_fall && $past(active)) |-> (mode_q == $past(mode_q))) else $error("mode changed inside frame"); // R4

endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
   import csp_pkg::*;
#(
   parameter int         NUM_REGS    = 8,
   parameter int         FIFO_DEPTH  = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] MODE_ADDR   = 7'h10,
   parameter logic [3:0] W12_NIB     = 4'hC,
   parameter logic [3:0] R12_NIB     = 4'hD
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_clk,
   input  logic                  ser_cs_n,
   input  logic                  ser_din,
   output logic                  ser_dout,
   output logic                  ser_dout_oe,
   output logic                  ser_irq_n,
   input  logic                  evt_valid,
   output logic                  evt_ready,
   input  logic [6:0]            evt_addr,
   input  logic [7:0]            evt_data,
   output logic [NUM_REGS*8-1:0] cfg_regs,
   output logic [11:0]           cfg_wide,
   output logic                  cfg_mode_b
);

   localparam int RAW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   initial begin : p_param_chk
      if (NUM_REGS < 1 || NUM_REGS > 64)  $error("NUM_REGS out of range");
      if (MODE_ADDR < 7'(NUM_REGS))       $error("MODE_ADDR overlaps register file");
      if (W12_NIB == R12_NIB)             $error("wide access nibbles must differ");
      if (MODE_ADDR[6:3] == W12_NIB || MODE_ADDR[6:3] == R12_NIB) $error("MODE_ADDR overlaps wide access");
   end

   // ---------------- synchronizers ----------------
   logic [2:0] s_bus;
   logic       s_sclk, s_cs_n, s_din;

   csp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({ser_din, ser_cs_n, ser_clk}),
      .q_out (s_bus)
   );
   assign s_sclk = s_bus[0];
   assign s_cs_n = s_bus[1];
   assign s_din  = s_bus[2];

   // ---------------- frame engine ----------------
   logic                      fifo_empty, fifo_full;
   logic [CSP_FRAME_BITS-1:0] fifo_head, rx_word, push_word;
   logic                      frame_done, frame_had_msg;
   logic                      fifo_push, fifo_pop;

   csp_frame #(.BITS(CSP_FRAME_BITS)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_sclk     (s_sclk),
      .s_cs_n     (s_cs_n),
      .s_din      (s_din),
      .mode_b_i   (cfg_mode_b),
      .tx_avail_i (~fifo_empty),
      .tx_word_i  (fifo_head),
      .dout_o     (ser_dout),
      .oe_o       (ser_dout_oe),
      .done_o     (frame_done),
      .had_msg_o  (frame_had_msg),
      .rx_word_o  (rx_word)
   );

   // ---------------- command decode ----------------
   csp_word_t  cmd;
   logic [6:0] cmd_addr;
   logic       is_w12, is_r12, is_rd8, addr_in_file, addr_is_mode;
   logic       wr8, wr_mode, wr_wide, reply_req, reply_push, evt_push;
   logic [7:0] rd_val;
   csp_word_t  reply_word;
   logic [7:0] reg_arr [NUM_REGS];
   logic       pend_v;
   csp_word_t  pend_w;
   logic       irq_q;

   assign cmd          = rx_word;
   assign cmd_addr     = cmd.hdr[7:1];
   assign is_w12       = (cmd.hdr[7:4] == W12_NIB);
   assign is_r12       = (cmd.hdr[7:4] == R12_NIB);
   assign is_rd8       = ~is_w12 & ~is_r12 & cmd.hdr[0];
   assign addr_in_file = ({1'b0, cmd_addr} < 8'(NUM_REGS));
   assign addr_is_mode = (cmd_addr == MODE_ADDR);

   assign wr8       = frame_done & ~is_w12 & ~is_r12 & ~cmd.hdr[0] & addr_in_file;
   assign wr_mode   = frame_done & ~is_w12 & ~is_r12 & ~cmd.hdr[0] & addr_is_mode;
   assign wr_wide   = frame_done & is_w12;
   assign reply_req = frame_done & (is_r12 | is_rd8);

   always_comb begin
      rd_val = 8'h00;
      if (addr_in_file)      rd_val = reg_arr[cmd_addr[RAW-1:0]];
      else if (addr_is_mode) rd_val = {7'b0, cfg_mode_b};
      if (is_r12) reply_word = '{hdr: {R12_NIB, cfg_wide[11:8]}, body: cfg_wide[7:0]};
      else        reply_word = csp_make(cmd_addr, 1'b1, rd_val);
   end

   // ---------------- register file ----------------
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               reg_arr[g] <= 8'h00;
         else if (wr8 && cmd_addr[RAW-1:0] == RAW'(g)) reg_arr[g] <= cmd.body;
      end
      assign cfg_regs[g*8 +: 8] = reg_arr[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode_b <= 1'b0;
         cfg_wide   <= 12'h000;
      end else begin
         if (wr_mode) cfg_mode_b <= cmd.body[0];
         if (wr_wide) cfg_wide   <= {cmd.hdr[3:0], cmd.body};
      end
   end

   // ---------------- outgoing message queue ----------------
   assign fifo_pop   = frame_done & frame_had_msg;
   assign reply_push = reply_req & (~fifo_full | fifo_pop);
   assign evt_push   = pend_v & s_cs_n & ~reply_push & ~fifo_full;
   assign fifo_push  = reply_push | evt_push;
   assign push_word  = reply_push ? reply_word : pend_w;

   csp_fifo #(.WIDTH(CSP_FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push),
      .push_data (push_word),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

   // status report holding slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_w <= '0;
      end else if (evt_valid && !pend_v) begin
         pend_v <= 1'b1;
         pend_w <= csp_make(evt_addr, 1'b0, evt_data);
      end else if (evt_push) begin
         pend_v <= 1'b0;
      end
   end
   assign evt_ready = ~pend_v;

   // ---------------- interrupt ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b1;
      else        irq_q <= ~(s_cs_n & ~fifo_empty);
   end
   assign ser_irq_n = irq_q;

   // ---------------- assertions ----------------
   AST_IRQ_NO_FALL_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_irq_n) |-> $past(s_cs_n)) else $error("irq fell during frame"); // R9
   AST_OE_FOLLOWS_CS:        assert property (@(posedge clk) disable iff (!rst_n) (s_cs_n && $past(s_cs_n)) |-> (!ser_dout_oe && !ser_dout)) else $error("output driven while deselected"); // R10
   AST_CFG_ONLY_ON_FRAME:    assert property (@(posedge clk) disable iff (!rst_n) (cfg_regs != $past(cfg_regs)) |-> $past(frame_done)) else $error("register changed without frame"); // R1
   AST_MODE_ONLY_ON_FRAME:   assert property (@(posedge clk) disable iff (!rst_n) (cfg_mode_b != $past(cfg_mode_b)) |-> $past(frame_done)) else $error("mode changed without frame"); // R4
   AST_PUSH_CS_HIGH:         assert property (@(posedge clk) disable iff (!rst_n) fifo_push |-> s_cs_n) else $error("queue loaded during frame"); // R12

endmodule

// File: tb/ctl_serial_port_test.sv
module ctl_serial_port_test;

   localparam int HP = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ser_clk, ser_cs_n, ser_din;
   logic        ser_dout, ser_dout_oe, ser_irq_n;
   logic        evt_valid, evt_ready;
   logic [6:0]  evt_addr;
   logic [7:0]  evt_data;
   logic [63:0] cfg_regs;
   logic [11:0] cfg_wide;
   logic        cfg_mode_b;

   always #4 clk = ~clk;

   ctl_serial_port uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_din(ser_din),
      .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe), .ser_irq_n(ser_irq_n),
      .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_addr(evt_addr), .evt_data(evt_data),
      .cfg_regs(cfg_regs), .cfg_wide(cfg_wide), .cfg_mode_b(cfg_mode_b)
   );

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   // reference model
   logic [7:0]  m_regs [8];
   logic        m_mode;
   logic [11:0] m_wide;
   logic [15:0] mq [4];
   int          mcnt;
   logic        m_pend;
   logic [15:0] m_pend_w;
   logic        last_oe, last_irq;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic m_push(input logic [15:0] w);
      if (mcnt < 4) begin
         mq[mcnt] = w;
         mcnt++;
      end
   endtask

   function automatic logic [7:0] m_read(input logic [6:0] a);
      if (a < 7'd8)        return m_regs[a[2:0]];
      else if (a == 7'h10) return {7'b0, m_mode};
      else                 return 8'h00;
   endfunction

   // expected reply of a complete frame, then apply its command
   task automatic m_commit(input logic [15:0] tx, output logic [15:0] exp_rx);
      logic [7:0] h, b;
      h = tx[15:8];
      b = tx[7:0];
      exp_rx = (mcnt > 0) ? mq[0] : 16'h0000;
      if (mcnt > 0) begin
         for (int k = 0; k < 3; k++) mq[k] = mq[k+1];
         mcnt--;
      end
      if (h[7:4] == 4'hC)      m_wide = {h[3:0], b};
      else if (h[7:4] == 4'hD) m_push({4'hD, m_wide});
      else if (h[0])           m_push({h[7:1], 1'b1, m_read(h[7:1])});
      else if (h[7:1] < 7'd8)  m_regs[h[3:1]] = b;
      else if (h[7:1] == 7'h10) m_mode = b[0];
      if (m_pend && mcnt < 4) begin
         m_push(m_pend_w);
         m_pend = 1'b0;
      end
   endtask

   function automatic logic [63:0] m_regs_flat();
      logic [63:0] f;
      for (int k = 0; k < 8; k++) f[k*8 +: 8] = m_regs[k];
      return f;
   endfunction

   // host side of one frame; mid_evt pulses a status report in the middle
   task automatic frame(input logic [15:0] tx, input int pulses, input bit idle_hi,
                        input bit mid_evt, output logic [15:0] rx);
      rx = 16'h0000;
      ser_clk = idle_hi;
      ser_din = 1'b0;
      cyc(HP);
      ser_cs_n = 1'b0;
      cyc(HP);
      for (int i = 0; i < pulses; i++) begin
         if (!m_mode) begin
            ser_din = tx[15-i];
            cyc(HP);
            rx[15-i] = ser_dout;
            ser_clk = ~ser_clk;
            cyc(HP);
            ser_clk = ~ser_clk;
            cyc(HP);
         end else begin
            ser_clk = ~ser_clk;
            ser_din = tx[15-i];
            cyc(HP);
            rx[15-i] = ser_dout;
            ser_clk = ~ser_clk;
            cyc(HP);
         end
         if (mid_evt && i == 8) begin
            evt_valid = 1'b1;
            cyc(1);
            evt_valid = 1'b0;
            cyc(4);
         end
      end
      last_oe  = ser_dout_oe;
      last_irq = ser_irq_n;
      ser_cs_n = 1'b1;
      cyc(12);
   endtask

   task automatic run(input string req, input logic [15:0] tx, input bit idle_hi);
      logic [15:0] rx, exp_rx;
      frame(tx, 16, idle_hi, 1'b0, rx);
      m_commit(tx, exp_rx);
      chk(req, {48'h0, rx}, {48'h0, exp_rx});
      chk("R9 irq after frame", {63'h0, ser_irq_n}, {63'h0, (mcnt == 0)});
      chk("R5 register file", cfg_regs, m_regs_flat());
   endtask

   task automatic send_evt(input logic [6:0] a, input logic [7:0] d);
      evt_addr  = a;
      evt_data  = d;
      evt_valid = 1'b1;
      cyc(1);
      evt_valid = 1'b0;
      if (mcnt < 4) m_push({a, 1'b0, d});
      else begin
         m_pend   = 1'b1;
         m_pend_w = {a, 1'b0, d};
      end
      cyc(6);
   endtask

   initial begin : watchdog
      repeat (180000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] rx, exp_rx;
      int unsigned seed_val;
      seed_val = $urandom(32'd7351);
      rst_n = 1'b0; ser_clk = 1'b0; ser_cs_n = 1'b1; ser_din = 1'b0;
      evt_valid = 1'b0; evt_addr = '0; evt_data = '0;
      for (int k = 0; k < 8; k++) m_regs[k] = 8'h00;
      m_mode = 1'b0; m_wide = 12'h000; mcnt = 0; m_pend = 1'b0; m_pend_w = '0;
      cyc(10);
      rst_n = 1'b1;
      cyc(5);

      // reset state
      chk("R9 reset irq", {63'h0, ser_irq_n}, 64'h1);
      chk("R10 reset oe", {62'h0, ser_dout_oe, ser_dout}, 64'h0);
      chk("R4 reset mode A", {63'h0, cfg_mode_b}, 64'h0);
      chk("R5 reset regs", cfg_regs, 64'h0);

      // idle frame with no-op command
      run("R8 idle frame zeros", 16'hFE00, 1'b0);
      chk("R10 oe during frame", {63'h0, last_oe}, 64'h1);

      // write then read back (data byte of read-back is junk)
      run("R5 write reg3", 16'h06A5, 1'b0);
      run("R6 read-back request", 16'h07FF, 1'b0);
      chk("R6 irq pending", {63'h0, ser_irq_n}, 64'h0);
      run("R3 mode A reply 07A5", 16'hFE00, 1'b0);

      // spontaneous status
      send_evt(7'h15, 8'h3C);
      chk("R7 irq on status", {63'h0, ser_irq_n}, 64'h0);
      run("R7 status message", 16'hFE00, 1'b0);

      // status arriving inside a frame is held until select rises
      evt_addr = 7'h2B; evt_data = 8'h81;
      frame(16'hFE00, 16, 1'b0, 1'b1, rx);
      m_commit(16'hFE00, exp_rx);
      m_push({7'h2B, 1'b0, 8'h81});
      chk("R9 irq high during frame", {63'h0, last_irq}, 64'h1);
      chk("R12 irq after held status", {63'h0, ser_irq_n}, 64'h0);
      run("R12 held status delivered", 16'hFE00, 1'b0);

      // short frame: no write, message not consumed
      run("R6 read-back reg3", 16'h0700, 1'b0);
      frame(16'h0611, 10, 1'b0, 1'b0, rx);
      chk("R1 short frame no write", cfg_regs, m_regs_flat());
      chk("R1 short frame keeps message", {63'h0, ser_irq_n}, 64'h0);
      run("R1 message after short frame", 16'hFE00, 1'b0);

      // clock idling high
      run("R2 idle-high write reg5", 16'h0A5C, 1'b1);
      run("R2 idle-high read-back", 16'h0B00, 1'b1);
      run("R2 idle-high reply", 16'hFE00, 1'b1);

      // 12-bit register
      run("R11 wide write", 16'hCA5B, 1'b0);
      chk("R11 wide value", {52'h0, cfg_wide}, 64'hA5B);
      run("R11 wide read request", 16'hD000, 1'b0);
      run("R11 wide reply DA5B", 16'hFE00, 1'b0);

      // mode B
      run("R4 select mode B", 16'h2001, 1'b0);
      chk("R4 mode flag", {63'h0, cfg_mode_b}, 64'h1);
      run("R4 mode B write reg6", 16'h0C5A, 1'b1);
      run("R4 mode B read-back", 16'h0D00, 1'b0);
      run("R4 mode B reply", 16'hFE00, 1'b0);
      run("R4 back to mode A", 16'h2000, 1'b0);
      chk("R4 mode flag cleared", {63'h0, cfg_mode_b}, 64'h0);

      // queue full: four status reports, fifth is held
      for (int k = 0; k < 4; k++) send_evt(7'(k + 1), 8'(8'h10 + k));
      chk("R12 ready with space", {63'h0, evt_ready}, 64'h1);
      send_evt(7'h05, 8'h99);
      chk("R12 held when full", {63'h0, evt_ready}, 64'h0);
      run("R12 first in order", 16'h0700, 1'b0);
      chk("R12 still held", {63'h0, evt_ready}, 64'h0);
      for (int k = 0; k < 5; k++) run("R12 drain order", 16'hFE00, 1'b0);
      run("R8 empty after drain", 16'hFE00, 1'b0);
      chk("R9 irq released", {63'h0, ser_irq_n}, 64'h1);

      // constrained random mix
      for (int it = 0; it < 70; it++) begin
         int unsigned op;
         bit          ih;
         logic [2:0]  ra;
         op = $urandom % 6;
         ih = 1'($urandom);
         ra = 3'($urandom);
         case (op)
            0: run(m_mode ? "R4 random write" : "R3 random write", {4'h0, ra, 1'b0, 8'($urandom)}, ih);
            1: run(m_mode ? "R4 random read-back" : "R6 random read-back", {4'h0, ra, 1'b1, 8'($urandom)}, ih);
            2: if (!m_pend) begin
                  send_evt(7'($urandom % 32), 8'($urandom));
                  chk("R7 random irq", {63'h0, ser_irq_n}, 64'h0);
               end
            3: run("R2 random no-op", 16'hFE00, ih);
            4: run("R4 random mode", {8'h20, 7'h0, 1'($urandom)}, ih);
            default: run("R11 random wide", {4'hC, 12'($urandom)}, ih);
         endcase
      end
      run("R4 restore mode A", 16'h2000, 1'b0);
      for (int k = 0; k < 6; k++) run("R12 final drain", 16'hFE00, 1'b0);
      chk("R11 final wide", {52'h0, cfg_wide}, {52'h0, m_wide});

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule